// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous memory that can take a new command on every enabled clock edge and never needs an idle cycle when the traffic turns between reads and writes. Commands, addresses and chip selects are registered on the rising edge. A read returns its word through an output register one enabled edge after the command. A write supplies its data two enabled edges after the command, and that data can be masked per 9-bit lane. If a read follows a write to the same address before the write has reached the array, the read returns the merged word that the write is about to store.

The shared data bus is split into an input bus and an output bus. A drive flag marks the cycles in which the memory would own the bus. The flag follows the pipelined read, write and deselect rules and is gated at once by output enable. A clock enable freezes every pipeline stage, the output register and any pending array write. The timing of the interface is fixed by the command pipeline, so there is no valid/ready pair and no back-pressure. The clock enable is the only way to stall, and while it is inactive the write data for a pending write must be held on the input bus.

Top module: `lw_sram`

## Requirements
- R1: A command is accepted only at an edge where `cke_n`=0, `csa_n`=0, `csb`=1, `csc_n`=0 and `start_n`=0. At any other enabled edge no access starts, and a write presented there leaves the array unchanged.
- R2: For an accepted command, `we_n`=1 means a read and `we_n`=0 means a write.
- R3: The data of a read appears on `rdata` with `bus_drive`=1 after the next enabled edge following the read command. `bus_drive` follows `oe_n` combinationally and is 0 whenever `oe_n`=1.
- R4: After the first enabled edge that follows a write command, `bus_drive` is 0 whatever `oe_n` is. At the second enabled edge, `wdata` is stored at the command's address, and that store completes the write.
- R5: Reads and writes may be issued on consecutive enabled edges in any mix, and every read returns the correct word.
- R6: Bit i of `lane_we_n` is sampled with the write command. When it is 0, data bits [9i+8:9i] are written. When it is 1, those bits keep their old contents.
- R7: After an enabled edge that accepts no read (a deselect, an idle edge or a write), `bus_drive` is 0 after the following enabled edge.
- R8: While `cke_n`=1, clock edges are ignored. No pipeline stage, output or pending write changes, and a pending write completes only at a later enabled edge.
- R9: A read accepted at the enabled edge right after a write to the same address returns the old word with the lanes enabled by that write replaced by the write's data.
- R10: After reset, `bus_drive` is 0 and no command is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high freezes the pipeline |
| csa_n | input | 1 | Chip select A, active low |
| csb | input | 1 | Chip select B, active high |
| csc_n | input | 1 | Chip select C, active low |
| start_n | input | 1 | Load control, low starts a command |
| we_n | input | 1 | Write enable, low selects a write |
| lane_we_n | input | LANES (2) | Per-lane write enables, active low |
| addr | input | ADDR_W (8) | Word address |
| wdata | input | LANES*LANE_W (18) | Write data, sampled two enabled edges after the write command |
| oe_n | input | 1 | Output enable, active low, combinational |
| rdata | output | LANES*LANE_W (18) | Registered read data |
| bus_drive | output | 1 | High when the memory would drive the shared bus |

## Verification
A write reaching the array and a read of the same address reaching the output register can fall on the same edge. This happens when a read command is issued on the edge right after a write to that address. The bench provokes it with full and partial lane masks, and also with stalled cycles placed between the two commands. A scoreboard models the array from the requirements and applies each write only at the edge where its data is taken. Each returned word must show the new lanes merged over the old ones in that same cycle.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_sram_decode.sv
module lw_sram_decode
  import lw_sram_pkg::*;
(
  input  logic csa_n,
  input  logic csb,
  input  logic csc_n,
  input  logic start_n,
  input  logic we_n,
  output op_e  op
);
  logic selected;

  assign selected = !csa_n && csb && !csc_n;

  always_comb begin
    op = OP_NONE;
    if (selected && !start_n) begin
      op = we_n ? OP_READ : OP_WRITE;
    end
  end
endmodule

// File: rtl/lw_sram_pipe.sv
module lw_sram_pipe
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  op_e               op_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LANES-1:0]  lane_en_in,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              s2_wr,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_lane_en,
  output logic              drive_q
);
  logic [LANES-1:0] s1_lane_en;

  // stage 1: registered command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op      <= OP_NONE;
      s1_addr    <= '0;
      s1_lane_en <= '0;
    end else if (!hold) begin
      s1_op      <= op_in;
      s1_addr    <= addr_in;
      s1_lane_en <= lane_en_in;
    end
  end

  // stage 2: write waiting for its data; drive flag for the read output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_wr      <= 1'b0;
      s2_addr    <= '0;
      s2_lane_en <= '0;
      drive_q    <= 1'b0;
    end else if (!hold) begin
      s2_wr      <= (s1_op == OP_WRITE);
      s2_addr    <= s1_addr;
      s2_lane_en <= s1_lane_en;
      drive_q    <= (s1_op == OP_READ);
    end
  end

  AST_WRITE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && s1_op == OP_WRITE) |=> s2_wr); // R4
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && s1_op == OP_READ) |=> drive_q); // R3
  AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && s1_op != OP_READ) |=> !drive_q); // R7
  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(s1_op) && $stable(s2_wr) && $stable(drive_q) && $stable(s2_addr))); // R8
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    hold,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_lane_en,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!hold && wr_en && wr_lane_en[g]) begin
        mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    assign rd_word[g*LANE_W +: LANE_W] = mem[rd_addr];
  end
endmodule

// File: rtl/lw_sram_merge.sv
module lw_sram_merge #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    hit,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*LANE_W-1:0] base,
  input  logic [LANES*LANE_W-1:0] upd,
  output logic [LANES*LANE_W-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = (hit && lane_en[g]) ?
      upd[g*LANE_W +: LANE_W] : base[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke_n,
  input  logic                    csa_n,
  input  logic                    csb,
  input  logic                    csc_n,
  input  logic                    start_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    bus_drive
);
  localparam int DATA_W = LANES * LANE_W;

  logic              hold;
  op_e               op_in;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic              s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lane_en;
  logic              drive_q;
  logic [DATA_W-1:0] array_word;
  logic [DATA_W-1:0] rd_merged;
  logic [DATA_W-1:0] rdata_q;
  logic              fwd_hit;

  assign hold = cke_n;

  lw_sram_decode u_decode (
    .csa_n   (csa_n),
    .csb     (csb),
    .csc_n   (csc_n),
    .start_n (start_n),
    .we_n    (we_n),
    .op      (op_in)
  );

  lw_sram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .op_in      (op_in),
    .addr_in    (addr),
    .lane_en_in (~lane_we_n),
    .s1_op      (s1_op),
    .s1_addr    (s1_addr),
    .s2_wr      (s2_wr),
    .s2_addr    (s2_addr),
    .s2_lane_en (s2_lane_en),
    .drive_q    (drive_q)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk        (clk),
    .hold       (hold),
    .wr_en      (s2_wr),
    .wr_addr    (s2_addr),
    .wr_lane_en (s2_lane_en),
    .wr_data    (wdata),
    .rd_addr    (s1_addr),
    .rd_word    (array_word)
  );

  // a write taking its data on this edge overlaps a read of the same word
  assign fwd_hit = s2_wr && (s2_addr == s1_addr);

  lw_sram_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .hit     (fwd_hit),
    .lane_en (s2_lane_en),
    .base    (array_word),
    .upd     (wdata),
    .merged  (rd_merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (!hold && s1_op == OP_READ) begin
      rdata_q <= rd_merged;
    end
  end

  assign rdata     = rdata_q;
  assign bus_drive = drive_q && !oe_n;

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && (start_n || csa_n || !csb || csc_n)) |=> (s1_op == OP_NONE)); // R1
  AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && s1_op == OP_WRITE) |=> !bus_drive); // R4
  AST_RDATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(rdata)); // R8
endmodule

// File: tb/lw_sram_tb_top.sv
module lw_sram_tb_top;
  localparam int CLK_P = 10;
  localparam int AW    = 8;
  localparam int DW    = 18;
  localparam logic [DW-1:0] JUNK = 18'h25A5A;
  localparam logic [2:0] SEL_OK = 3'b010; // {csc_n, csb, csa_n}

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_n = 1'b1, csa_n = 1'b1, csb = 1'b0, csc_n = 1'b1, start_n = 1'b1, we_n = 1'b1;
  logic [1:0] lane_we_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic oe_n = 1'b0;
  logic [DW-1:0] rdata;
  logic bus_drive;

  always #(CLK_P/2) clk = ~clk;

  lw_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .csa_n(csa_n), .csb(csb), .csc_n(csc_n),
    .start_n(start_n), .we_n(we_n), .lane_we_n(lane_we_n), .addr(addr),
    .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .bus_drive(bus_drive)
  );

  typedef struct {
    bit          drv;
    logic [DW-1:0] data;
    bit          oe;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] model [1 << AW];
  bit w1_v = 0, w2_v = 0;
  logic [AW-1:0] w1_a, w2_a;
  logic [1:0] w1_m, w2_m;
  logic [DW-1:0] w1_d, w2_d;
  bit r1_v = 0;
  logic [AW-1:0] r1_a;
  string r1_tag = "";
  bit out_drv = 0;
  logic [DW-1:0] out_data = '0;
  string out_tag = "";

  // driver: one clock cycle, scoreboard entry pushed after the edge
  task automatic cyc(input bit hold, input logic [2:0] sel, input bit ld_n, input bit wr_n,
                     input logic [AW-1:0] a, input logic [1:0] m, input logic [DW-1:0] d,
                     input bit oe, input string tag);
    bit go;
    exp_t e;
    @(negedge clk);
    cke_n = hold; csa_n = sel[0]; csb = sel[1]; csc_n = sel[2];
    start_n = ld_n; we_n = wr_n; addr = a; lane_we_n = m; oe_n = oe;
    wdata = w2_v ? w2_d : JUNK;
    @(posedge clk);
    if (!hold) begin
      if (w2_v) begin
        for (int g = 0; g < 2; g++)
          if (!w2_m[g]) model[w2_a][g*9 +: 9] = w2_d[g*9 +: 9];
      end
      out_drv = r1_v;
      if (r1_v) begin
        out_data = model[r1_a];
        out_tag = r1_tag;
      end else begin
        out_tag = tag;
      end
      go = (sel == SEL_OK) && !ld_n;
      w2_v = w1_v; w2_a = w1_a; w2_m = w1_m; w2_d = w1_d;
      w1_v = go && !wr_n; w1_a = a; w1_m = m; w1_d = d;
      r1_v = go && wr_n; r1_a = a; r1_tag = tag;
    end
    e.drv = out_drv; e.data = out_data; e.oe = oe; e.tag = hold ? tag : out_tag;
    sb_q.push_back(e);
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit oe, input string tag);
    cyc(0, SEL_OK, 0, 1, a, 2'b11, '0, oe, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [1:0] m, input logic [DW-1:0] d, input string tag);
    cyc(0, SEL_OK, 0, 0, a, m, d, 0, tag);
  endtask
  task automatic nop(input bit oe, input string tag);
    cyc(0, SEL_OK, 1, 1, '0, 2'b11, '0, oe, tag);
  endtask
  task automatic stall(input bit oe, input string tag);
    cyc(1, SEL_OK, 0, 0, 8'hEE, 2'b00, JUNK, oe, tag);
  endtask

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a, ~a, 2'b10};
  endfunction

  // monitor: pops and compares away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      while (sb_q.size() > 0) begin
        exp_t e;
        bit exp_bus;
        e = sb_q.pop_front();
        exp_bus = e.drv && !e.oe;
        checks++;
        if (bus_drive !== exp_bus) begin
          errors++;
          $display("FAIL %s bus_drive actual %0b expected %0b at %0t", e.tag, bus_drive, exp_bus, $time);
        end
        if (e.drv) begin
          checks++;
          if (rdata !== e.data) begin
            errors++;
            $display("FAIL %s rdata actual %h expected %h at %0t", e.tag, rdata, e.data, $time);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    checks++; // R10
    if (bus_drive !== 1'b0) begin
      errors++;
      $display("FAIL R10 bus_drive actual %0b expected 0", bus_drive);
    end
    @(negedge clk);
    rst_n = 1'b1;
    checks++; // R10 after release with oe_n low
    if (bus_drive !== 1'b0) begin
      errors++;
      $display("FAIL R10 bus_drive actual %0b expected 0", bus_drive);
    end

    // R2/R5: fill and read back-to-back
    for (int a = 0; a < 8; a++) wr(a[AW-1:0], 2'b00, pat(a[AW-1:0]), "R2");
    for (int a = 0; a < 8; a++) rd(a[AW-1:0], 0, "R5");
    wr(8'd20, 2'b00, pat(8'd20), "R2");
    wr(8'd21, 2'b00, pat(8'd21), "R2");
    wr(8'd22, 2'b00, pat(8'd22), "R2");
    nop(0, "R7"); nop(0, "R7");

    // R5: turn-around on every edge
    wr(8'd10, 2'b00, 18'h3C0F1, "R5");
    rd(8'd3, 0, "R5");
    wr(8'd11, 2'b00, 18'h01234, "R5");
    rd(8'd10, 0, "R5");
    rd(8'd11, 0, "R5");

    // R9 and R6: read right after write, full and partial lanes
    wr(8'd20, 2'b00, 18'h2BEEF, "R9");
    rd(8'd20, 0, "R9");
    wr(8'd21, 2'b10, 18'h3FFFF, "R6");
    rd(8'd21, 0, "R6");
    wr(8'd22, 2'b01, 18'h00000, "R6");
    rd(8'd22, 0, "R6");
    wr(8'd22, 2'b11, 18'h15555, "R6");
    rd(8'd22, 0, "R6");
    nop(0, "R7");

    // R3: output enable gating of read data
    rd(8'd2, 0, "R3");
    nop(1, "R3");
    rd(8'd2, 0, "R3");
    nop(0, "R3");
    // R4: write releases the bus even with oe_n low
    rd(8'd1, 0, "R4");
    wr(8'd30, 2'b00, 18'h0ABCD, "R4");
    nop(0, "R4");
    rd(8'd30, 0, "R4");
    nop(0, "R4");

    // R1/R7: deselects and idle edges start nothing
    rd(8'd4, 0, "R7");
    cyc(0, 3'b011, 0, 0, 8'd4, 2'b00, 18'h11111, 0, "R1");
    cyc(0, 3'b000, 0, 0, 8'd4, 2'b00, 18'h22222, 0, "R1");
    cyc(0, 3'b110, 0, 0, 8'd4, 2'b00, 18'h33333, 0, "R1");
    cyc(0, SEL_OK, 1, 0, 8'd4, 2'b00, 18'h04444, 0, "R1");
    nop(0, "R1"); nop(0, "R1");
    rd(8'd4, 0, "R1");
    nop(0, "R1");

    // R8: stalls freeze output and pending writes
    rd(8'd5, 0, "R8");
    stall(0, "R8"); stall(1, "R8"); stall(0, "R8");
    rd(8'd6, 0, "R8");
    wr(8'd40, 2'b00, 18'h2D00D, "R8");
    stall(0, "R8");
    nop(0, "R8");
    stall(0, "R8");
    rd(8'd40, 0, "R8");
    wr(8'd41, 2'b01, 18'h3F00F, "R8");
    stall(0, "R8"); stall(0, "R8");
    rd(8'd41, 0, "R9");
    nop(0, "R8");

    // final readback
    for (int a = 0; a < 8; a++) rd(a[AW-1:0], 0, "R5");
    rd(8'd21, 0, "R6");
    rd(8'd22, 0, "R6");
    nop(0, "R7"); nop(0, "R7");

    @(posedge clk);
    #(CLK_P/2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule